// File: doc/BRIEF.md
# Shadow Page Table Walker

This block sits beside a translation cache that covers a window of shadow addresses. When that cache misses, it hands the walker the shadow page number. Each 4 KB shadow page has one 32-bit entry in a single-level array in memory, and the array is indexed directly. The walker computes the entry's address from a programmable base and window start, and fetches the entry with one memory read. It then returns the physical frame and permissions, or it reports a fault.

The requester may report that it has just set the accessed or dirty state for the page. In that case the walker merges those bits into the entry and writes the entry back at the same address, but only if the entry changes. An entry with a clear valid bit means the page is not resident. For such an entry the walker writes the entry back with a cause marker bit set, so that a handler can tell a paging fault from a real memory error. It also pulses an exception output and captures the faulting shadow address in a register that can be read over the configuration port.

Only one walk is in progress at a time.

Top module: `shadow_pt_walker`

## Requirements
- R1: After reset, the outputs are as follows: `req_ready` is 1; `mem_req`, `rsp_valid` and `exc_pulse` are 0; every configuration register reads 0.
- R2: Configuration register 0 holds the table base, and its two low bits always read 0. Register 1 holds the window start page. Register 2 holds the captured fault address and ignores writes.
- R3: Each walk issues exactly one read, at address base + (page number − window start) × 4.
- R4: The entry layout is: bit 0 valid, bit 1 accessed, bit 2 dirty, bits 4:3 permission, bit 5 fault marker, bits 31:12 frame number. A valid entry gives a response with `rsp_fault` = 0 and the entry's frame and permission. `rsp_dirty` is the entry's dirty bit after the merge.
- R5: For a valid entry, the request flags are ORed into bit 1 and bit 2. If that changes the entry, exactly one write of the merged entry goes to the read address before the response. If nothing changes, no write is issued.
- R6: For an invalid entry, the entry is written back with bit 5 set, and the response has `rsp_fault` = 1.
- R7: An invalid entry raises `exc_pulse` for exactly one cycle. At that point configuration register 2 captures the page number shifted left by 12.
- R8: `req_ready` stays low from the cycle after a request is accepted until the response handshake completes.
- R9: While `mem_req` waits for `mem_gnt`, its address, data and direction stay stable. While `rsp_valid` waits for `rsp_ready`, the response fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Walker idle, accepts a request |
| req_spn | input | 20 | Shadow page number of the miss |
| req_set_acc | input | 1 | Accessed state newly set by requester |
| req_set_dirty | input | 1 | Dirty state newly set by requester |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_fault | output | 1 | Entry was not resident |
| rsp_pfn | output | 20 | Physical frame number |
| rsp_perm | output | 2 | Permission field |
| rsp_dirty | output | 1 | Merged dirty bit |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| exc_pulse | output | 1 | External fault exception pulse |

## Verification
A wrong walk state shows up at the memory port within one grant. The symptoms are a second read, a read at the wrong offset, or a write-back when the entry did not change. A bad merge or decode appears in the written word and in the response fields as soon as `rsp_valid` rises. A broken handshake appears as `req_ready` rising early or as response fields moving while back-pressure holds them. Errors in fault handling show up in three places: the width of the exception pulse, the missing marker bit in the written entry, and the captured address read back right after the walk.

// File: rtl/spw_pkg.sv
package spw_pkg;
  localparam int unsigned ENT_W   = 32;
  localparam int unsigned V_BIT   = 0;
  localparam int unsigned A_BIT   = 1;
  localparam int unsigned D_BIT   = 2;
  localparam int unsigned P_LO    = 3;
  localparam int unsigned P_HI    = 4;
  localparam int unsigned M_BIT   = 5;
  localparam int unsigned PFN_LO  = 12;
  localparam int unsigned PFN_W   = ENT_W - PFN_LO;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_DECODE, S_WB, S_RESP
  } walk_state_e;
endpackage

// File: rtl/spw_cfg_regs.sv
module spw_cfg_regs #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SPN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] cap_addr,
  output logic [ADDR_W-1:0] base_o,
  output logic [SPN_W-1:0]  start_o
);
  logic [ADDR_W-1:0] base_q, fault_q;
  logic [SPN_W-1:0]  start_q;
  logic base_en, start_en;

  assign base_en  = cfg_we && (cfg_addr == 2'd0);
  assign start_en = cfg_we && (cfg_addr == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
      fault_q <= '0;
    end else begin
      if (base_en)  base_q  <= {cfg_wdata[ADDR_W-1:2], 2'b00};
      if (start_en) start_q <= cfg_wdata[SPN_W-1:0];
      if (cap_en)   fault_q <= cap_addr;
    end
  end

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = base_q;
      2'd1:    cfg_rdata = ADDR_W'(start_q);
      2'd2:    cfg_rdata = fault_q;
      default: cfg_rdata = '0;
    endcase
  end

  assign base_o  = base_q;
  assign start_o = start_q;

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (fault_q == $past(cap_addr)));
  a_r2_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    base_q[1:0] == 2'b00);
endmodule

// File: rtl/spw_addr_gen.sv
module spw_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SPN_W  = 20
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SPN_W-1:0]  start_i,
  input  logic [SPN_W-1:0]  spn_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [SPN_W-1:0]  off;
  logic [ADDR_W-1:0] off_ext;

  assign off     = spn_i - start_i;
  assign off_ext = ADDR_W'(off);
  assign addr_o  = base_i + (off_ext << 2);
endmodule

// File: rtl/spw_entry_decode.sv
module spw_entry_decode
  import spw_pkg::*;
(
  input  logic [ENT_W-1:0] entry_i,
  input  logic             set_acc_i,
  input  logic             set_dirty_i,
  output logic [ENT_W-1:0] merged_o,
  output logic             valid_o,
  output logic             wb_o,
  output logic [PFN_W-1:0] pfn_o,
  output logic [1:0]       perm_o,
  output logic             dirty_o
);
  always_comb begin
    merged_o = entry_i;
    if (entry_i[V_BIT]) begin
      merged_o[A_BIT] = entry_i[A_BIT] | set_acc_i;
      merged_o[D_BIT] = entry_i[D_BIT] | set_dirty_i;
    end else begin
      merged_o[M_BIT] = 1'b1;
    end
  end

  assign valid_o = entry_i[V_BIT];
  assign wb_o    = (merged_o != entry_i);
  assign pfn_o   = merged_o[ENT_W-1:PFN_LO];
  assign perm_o  = merged_o[P_HI:P_LO];
  assign dirty_o = merged_o[D_BIT];
endmodule

// File: rtl/shadow_pt_walker.sv
module shadow_pt_walker
  import spw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SPN_W      = 20,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SPN_W-1:0]  req_spn,
  input  logic              req_set_acc,
  input  logic              req_set_dirty,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [1:0]        rsp_perm,
  output logic              rsp_dirty,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ENT_W-1:0]  mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [ENT_W-1:0]  mem_rdata,
  output logic              exc_pulse
);
  walk_state_e state_q, state_d;
  logic [SPN_W-1:0] spn_q;
  logic             acc_q, dirty_q;
  logic [ENT_W-1:0] entry_q;
  logic             req_en, ent_en;

  logic [ADDR_W-1:0] base, ent_addr, cap_addr;
  logic [SPN_W-1:0]  start;
  logic [ENT_W-1:0]  merged;
  logic              ent_valid, need_wb;

  spw_cfg_regs #(.ADDR_W(ADDR_W), .SPN_W(SPN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cap_en(exc_pulse),
    .cap_addr(cap_addr), .base_o(base), .start_o(start)
  );

  spw_addr_gen #(.ADDR_W(ADDR_W), .SPN_W(SPN_W)) u_addr (
    .base_i(base), .start_i(start), .spn_i(spn_q), .addr_o(ent_addr)
  );

  spw_entry_decode u_dec (
    .entry_i(entry_q), .set_acc_i(acc_q), .set_dirty_i(dirty_q),
    .merged_o(merged), .valid_o(ent_valid), .wb_o(need_wb),
    .pfn_o(rsp_pfn), .perm_o(rsp_perm), .dirty_o(rsp_dirty)
  );

  assign cap_addr = ADDR_W'(spn_q) << PAGE_SHIFT;
  assign req_en   = (state_q == S_IDLE) && req_valid;
  assign ent_en   = (state_q == S_RD_WAIT) && mem_rvalid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:    if (req_valid)  state_d = S_RD_REQ;
      S_RD_REQ:  if (mem_gnt)    state_d = S_RD_WAIT;
      S_RD_WAIT: if (mem_rvalid) state_d = S_DECODE;
      S_DECODE:  state_d = need_wb ? S_WB : S_RESP;
      S_WB:      if (mem_gnt)    state_d = S_RESP;
      S_RESP:    if (rsp_ready)  state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      spn_q   <= '0;
      acc_q   <= 1'b0;
      dirty_q <= 1'b0;
      entry_q <= '0;
    end else begin
      state_q <= state_d;
      if (req_en) begin
        spn_q   <= req_spn;
        acc_q   <= req_set_acc;
        dirty_q <= req_set_dirty;
      end
      if (ent_en) entry_q <= mem_rdata;
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign mem_req   = (state_q == S_RD_REQ) || (state_q == S_WB);
  assign mem_we    = (state_q == S_WB);
  assign mem_addr  = ent_addr;
  assign mem_wdata = merged;
  assign rsp_valid = (state_q == S_RESP);
  assign rsp_fault = !ent_valid;
  assign exc_pulse = (state_q == S_DECODE) && !ent_valid;

  a_r8_one_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && (!mem_we || $stable(mem_wdata))));
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pfn)
                                   && $stable(rsp_fault) && $stable(rsp_perm)));
  a_r7_exc_single: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |=> !exc_pulse);
  a_r6_marker_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[V_BIT] || mem_wdata[M_BIT]));
endmodule

// File: tb/shadow_pt_walker_bench.sv
module shadow_pt_walker_bench;
  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        req_valid, req_ready, req_set_acc, req_set_dirty;
  logic [19:0] req_spn;
  logic        rsp_valid, rsp_ready, rsp_fault, rsp_dirty;
  logic [19:0] rsp_pfn;
  logic [1:0]  rsp_perm;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid, exc_pulse;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  shadow_pt_walker u_shadow_pt_walker (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_spn(req_spn), .req_set_acc(req_set_acc),
    .req_set_dirty(req_set_dirty), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm),
    .rsp_dirty(rsp_dirty), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .exc_pulse(exc_pulse)
  );

  // memory model: grant after gnt_lat wait cycles, read data two edges later
  logic [31:0] mem [64];
  int gnt_lat = 0;
  int gcnt, rd_cnt, wr_cnt, exc_cnt, exc_run, exc_max;
  logic [31:0] last_rd, last_wr;
  logic [31:0] rd_data;
  logic        rd_stage;

  assign mem_gnt = mem_req && (gcnt >= gnt_lat);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt <= 0; rd_stage <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0;
    end else begin
      if (mem_req && !mem_gnt) gcnt <= gcnt + 1; else gcnt <= 0;
      rd_stage   <= mem_req && mem_gnt && !mem_we;
      mem_rvalid <= rd_stage;
      mem_rdata  <= rd_data;
      if (mem_req && mem_gnt && !mem_we) begin
        rd_data <= mem[mem_addr[7:2]];
        rd_cnt  <= rd_cnt + 1;
        last_rd <= mem_addr;
      end
      if (mem_req && mem_gnt && mem_we) begin
        mem[mem_addr[7:2]] <= mem_wdata;
        wr_cnt  <= wr_cnt + 1;
        last_wr <= mem_addr;
      end
      if (exc_pulse) begin
        exc_cnt <= exc_cnt + 1;
        exc_run <= exc_run + 1;
        if (exc_run + 1 > exc_max) exc_max <= exc_run + 1;
      end else exc_run <= 0;
    end
  end

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1; d = cfg_rdata;
  endtask

  logic [19:0] g_pfn; logic [1:0] g_perm; logic g_fault, g_dirty;

  task automatic do_walk(input logic [19:0] spn, input logic a, input logic d, input int hold);
    @(negedge clk); req_valid = 1'b1; req_spn = spn; req_set_acc = a; req_set_dirty = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    g_pfn = rsp_pfn; g_perm = rsp_perm; g_fault = rsp_fault; g_dirty = rsp_dirty;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_pfn == g_pfn && rsp_fault == g_fault, "R9 response held", {11'b0, rsp_valid, rsp_pfn}, {12'h001, g_pfn});
      chk(!req_ready, "R8 ready low during walk", {31'b0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk); rsp_ready = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(req_ready && !mem_req && !rsp_valid && !exc_pulse, "R1 reset outputs",
        {28'b0, req_ready, mem_req, rsp_valid, exc_pulse}, 32'h8);
    for (int i = 0; i < 3; i++) begin
      cfg_read(2'(i), v);
      chk(v == 0, "R1 cfg reset", v, 32'd0);
    end
  endtask

  task automatic t_cfg;
    logic [31:0] v;
    cfg_write(2'd0, 32'h0000_0403);
    cfg_read(2'd0, v); chk(v == 32'h400, "R2 base aligned", v, 32'h400);
    cfg_write(2'd1, 32'h0000_0100);
    cfg_read(2'd1, v); chk(v == 32'h100, "R2 window start", v, 32'h100);
    cfg_write(2'd2, 32'hDEAD_BEEF);
    cfg_read(2'd2, v); chk(v == 32'h0, "R2 fault reg read-only", v, 32'h0);
  endtask

  task automatic t_clean_hit;
    int r0, w0;
    mem[5] = 32'hABCD_E017;
    r0 = rd_cnt; w0 = wr_cnt;
    do_walk(20'h00105, 1'b0, 1'b0, 0);
    chk(rd_cnt - r0 == 1, "R3 single read", rd_cnt - r0, 1);
    chk(last_rd == 32'h414, "R3 entry address", last_rd, 32'h414);
    chk(g_pfn == 20'hABCDE && g_perm == 2'd2 && !g_fault && g_dirty, "R4 decode",
        {g_pfn, 6'b0, g_perm, 2'b0, g_fault, g_dirty}, {20'hABCDE, 6'b0, 2'd2, 2'b0, 1'b0, 1'b1});
    chk(wr_cnt == w0, "R5 no write when unchanged", wr_cnt - w0, 0);
  endtask

  task automatic t_set_bits;
    int w0;
    mem[9] = 32'h1234_5009;
    w0 = wr_cnt;
    do_walk(20'h00109, 1'b1, 1'b1, 0);
    chk(wr_cnt - w0 == 1, "R5 one write-back", wr_cnt - w0, 1);
    chk(last_wr == 32'h424, "R5 write address", last_wr, 32'h424);
    chk(mem[9] == 32'h1234_500F, "R5 merged entry", mem[9], 32'h1234_500F);
    chk(g_dirty && g_perm == 2'd1, "R4 dirty and perm", {30'b0, g_perm[0], g_dirty}, 32'h3);
    mem[10] = 32'h1111_1001;
    do_walk(20'h0010A, 1'b1, 1'b0, 0);
    chk(mem[10] == 32'h1111_1003, "R5 accessed only", mem[10], 32'h1111_1003);
    chk(!g_dirty, "R4 dirty stays clear", {31'b0, g_dirty}, 0);
  endtask

  task automatic t_fault;
    logic [31:0] v;
    int e0;
    mem[20] = 32'h0;
    e0 = exc_cnt; exc_max = 0;
    do_walk(20'h00114, 1'b1, 1'b1, 0);
    chk(g_fault, "R6 fault response", {31'b0, g_fault}, 1);
    chk(mem[20] == 32'h20, "R6 cause marker written", mem[20], 32'h20);
    chk(exc_cnt - e0 == 1 && exc_max == 1, "R7 single pulse", exc_cnt - e0, 1);
    cfg_read(2'd2, v);
    chk(v == 32'h0011_4000, "R7 captured address", v, 32'h0011_4000);
  endtask

  task automatic t_backpressure;
    int r0;
    gnt_lat = 3;
    mem[33] = 32'h5555_5001;
    do_walk(20'h00121, 1'b0, 1'b1, 5);
    chk(mem[33] == 32'h5555_5005, "R9 write under slow grant", mem[33], 32'h5555_5005);
    r0 = rd_cnt;
    mem[34] = 32'h6666_6019;
    do_walk(20'h00122, 1'b0, 1'b0, 3);
    chk(rd_cnt - r0 == 1, "R8 one read per walk", rd_cnt - r0, 1);
    chk(g_pfn == 20'h66666 && g_perm == 2'd3, "R4 decode slow path", {12'b0, g_pfn}, 32'h66666);
    gnt_lat = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    rd_cnt = 0; wr_cnt = 0; exc_cnt = 0; exc_run = 0; exc_max = 0;
    last_rd = '0; last_wr = '0; rd_data = '0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    req_valid = 0; req_spn = 0; req_set_acc = 0; req_set_dirty = 0; rsp_ready = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_cfg;
    t_clean_hit;
    t_set_bits;
    t_fault;
    t_backpressure;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule